// File: doc/BRIEF.md
# Compacting issue queue

This block holds renamed instructions that wait for their source operands. Each stored entry carries a destination tag and two source operands. Every source has its own tag, an enable flag and a ready flag. Entries are kept packed against position 0 in arrival order, so position alone tells their age. Position 0 is the oldest and the highest occupied position is the youngest. New instructions always go into the free end, at the position named by the occupancy count. That count is the queue's only write pointer.

Each cycle the queue looks at the entries it holds. Up to two entries whose enabled sources are all ready are granted, oldest first. Their destination tags are presented on the grant outputs. At the clock edge the granted entries vanish and the remaining entries slide down by one or two positions, so the free space stays in one piece at the top. In the same edge, up to two new instructions are appended behind the survivors.

Result tags broadcast on the wake inputs mark every matching enabled source as ready. This applies to entries already stored and to instructions being written in that same cycle.

Top module: `collapse_iq`

## Requirements
- R1: While `rst_n` is low and after its release, `occ` is 0, `gnt_vld` is 0 and `in_rdy` is 1 when no input is offered.
- R2: Accepted instructions are appended directly behind the entries already held, slot 0 before slot 1. Valid entries fill positions 0 to `occ`-1 with no gap, and `occ` never exceeds DEPTH.
- R3: `in_rdy` is 1 exactly when the free positions (DEPTH - `occ`) are at least the number of set bits of `in_vld`. When `in_rdy` is 0, nothing offered that cycle is stored and it is never granted.
- R4: An entry requests a grant only when every source whose enable flag is 1 has its ready flag at 1. A source whose enable flag is 0 never blocks the entry.
- R5: At most two grants are given per cycle. `gnt_dst` bits [5:0] (grant slot 0) carry the oldest requesting entry and bits [11:6] (grant slot 1) the next older requesting entry. `gnt_vld[1]` is never 1 while `gnt_vld[0]` is 0. Grants depend only on the stored state of the current cycle.
- R6: Granted entries leave at the clock edge and the other entries keep their relative age order. `occ` becomes `occ` + accepted - granted, and it is unchanged in a cycle with neither.
- R7: A wake input w is active when `wk_vld[w]` is 1 and its tag is `wk_tag[6w+5:6w]`. An active wake input sets the ready flag of every stored enabled source with an equal tag at the clock edge. The affected entry can be granted from the next cycle on, not in the cycle of the broadcast.
- R8: A broadcast in the cycle an instruction is written also sets the matching enabled sources of that new instruction.
- R9: A single instruction may be offered on either input slot. If only `in_vld[1]` is set, that instruction is stored as the one new entry.
- R10: An instruction is never granted in the cycle it is offered. When grants and writes happen in the same cycle, the new entries land directly behind the surviving entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_vld | input | 2 | Per-slot valid for incoming instructions |
| in_dst | input | 12 | Destination tags, slot 0 in bits [5:0] |
| in_a_en | input | 2 | Per-slot enable of source A |
| in_a_tag | input | 12 | Per-slot tag of source A |
| in_a_rdy | input | 2 | Per-slot initial ready flag of source A |
| in_b_en | input | 2 | Per-slot enable of source B |
| in_b_tag | input | 12 | Per-slot tag of source B |
| in_b_rdy | input | 2 | Per-slot initial ready flag of source B |
| in_rdy | output | 1 | The offered instructions are accepted this cycle |
| wk_vld | input | 2 | Per-channel wake broadcast valid |
| wk_tag | input | 12 | Per-channel wake broadcast tag |
| gnt_vld | output | 2 | Grant slot valid, slot 0 the older |
| gnt_dst | output | 12 | Destination tags of the granted entries |
| occ | output | 4 | Number of valid entries, equal to the write position |

## Verification
The hardest state to reach from the ports is a nearly full queue in which three things happen at once. A write is refused, a grant takes an entry from the far end, and a wake lands on an instruction in the very cycle it is written. The stimulus builds this state by appending pairs of instructions that wait on tags never broadcast, until only one slot stays free. It then tries a two-instruction write that must be refused, fills the last slot from input slot 1 alone, and offers a write to the full queue while its youngest entry is being granted. It ends by writing one instruction together with a broadcast of its own source tag. The oldest and youngest entries are woken so that a two-grant cycle spans the whole queue.

// File: rtl/collapse_iq_pkg.sv
package collapse_iq_pkg;

  localparam int TAG_W = 6;
  localparam int IN_N  = 2;
  localparam int GNT_N = 2;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    logic en;
    tag_t tag;
    logic rdy;
  } src_t;

  typedef struct packed {
    logic vld;
    tag_t dst;
    src_t s0;
    src_t s1;
  } iqe_t;

  // entry may ask for a grant: valid and no enabled source still waiting
  function automatic logic iqe_req(input iqe_t e);
    return e.vld && (!e.s0.en || e.s0.rdy) && (!e.s1.en || e.s1.rdy);
  endfunction

endpackage

// File: rtl/collapse_iq_wake.sv
module collapse_iq_wake
  import collapse_iq_pkg::*;
#(
  parameter int WK_N = 2
) (
  input  iqe_t                    e_i,
  input  logic [WK_N-1:0]         wk_vld,
  input  logic [WK_N*TAG_W-1:0]   wk_tag,
  output iqe_t                    e_o
);

  always_comb begin
    e_o = e_i;
    for (int w = 0; w < WK_N; w++) begin
      if (wk_vld[w]) begin
        if (e_i.s0.en && (e_i.s0.tag == wk_tag[w*TAG_W +: TAG_W])) e_o.s0.rdy = 1'b1;
        if (e_i.s1.en && (e_i.s1.tag == wk_tag[w*TAG_W +: TAG_W])) e_o.s1.rdy = 1'b1;
      end
    end
  end

endmodule

// File: rtl/collapse_iq_pick.sv
module collapse_iq_pick
  import collapse_iq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  iqe_t                 q    [DEPTH],
  output logic [DEPTH-1:0]     take,
  output logic [GNT_N-1:0]     gvld,
  output logic [IDX_W-1:0]     gidx [GNT_N]
);

  // positional priority scan from the oldest end
  always_comb begin
    int cnt;
    cnt  = 0;
    take = '0;
    gvld = '0;
    for (int k = 0; k < GNT_N; k++) gidx[k] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (iqe_req(q[i]) && (cnt < GNT_N)) begin
        take[i]   = 1'b1;
        gvld[cnt] = 1'b1;
        gidx[cnt] = IDX_W'(i);
        cnt       = cnt + 1;
      end
    end
  end

  AST_GNT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    gvld[1] |-> (gvld[0] && (gidx[1] > gidx[0])))
    else $error("grant slot 1 without an older slot 0 grant"); // R5

  AST_GNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(take) <= GNT_N)
    else $error("more grants than grant slots"); // R5

endmodule

// File: rtl/collapse_iq_shift.sv
module collapse_iq_shift
  import collapse_iq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OCC_W = 4
) (
  input  iqe_t                q     [DEPTH],
  input  logic [DEPTH-1:0]    take,
  input  logic [OCC_W-1:0]    base,
  input  iqe_t                nw    [IN_N],
  input  logic [1:0]          n_new,
  output iqe_t                qn    [DEPTH]
);

  logic [1:0] below [DEPTH];

  // grants seen below each position = distance that entry slides down
  always_comb begin
    logic [1:0] run;
    run = '0;
    for (int j = 0; j < DEPTH; j++) begin
      below[j] = run;
      if (take[j]) run = run + 2'd1;
    end
  end

  // each position picks itself, one above or two above; then new entries
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      qn[i] = '0;
      for (int s = 0; s <= GNT_N; s++) begin
        int j;
        j = (i + s < DEPTH) ? (i + s) : (DEPTH - 1);
        if ((i + s < DEPTH) && q[j].vld && !take[j] && (int'(below[j]) == s))
          qn[i] = q[j];
      end
      begin
        int k;
        k = i - int'(base);
        if ((k >= 0) && (k < int'(n_new)))
          qn[i] = nw[(k == 1) ? 1 : 0];
      end
    end
  end

endmodule

// File: rtl/collapse_iq.sv
module collapse_iq
  import collapse_iq_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int WK_N  = 2,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IN_N-1:0]         in_vld,
  input  logic [IN_N*TAG_W-1:0]   in_dst,
  input  logic [IN_N-1:0]         in_a_en,
  input  logic [IN_N*TAG_W-1:0]   in_a_tag,
  input  logic [IN_N-1:0]         in_a_rdy,
  input  logic [IN_N-1:0]         in_b_en,
  input  logic [IN_N*TAG_W-1:0]   in_b_tag,
  input  logic [IN_N-1:0]         in_b_rdy,
  output logic                    in_rdy,
  input  logic [WK_N-1:0]         wk_vld,
  input  logic [WK_N*TAG_W-1:0]   wk_tag,
  output logic [GNT_N-1:0]        gnt_vld,
  output logic [GNT_N*TAG_W-1:0]  gnt_dst,
  output logic [OCC_W-1:0]        occ
);

  iqe_t              q     [DEPTH];
  iqe_t              q_sh  [DEPTH];
  iqe_t              q_nx  [DEPTH];
  iqe_t              in_e  [IN_N];
  iqe_t              nw    [IN_N];
  logic [DEPTH-1:0]  take;
  logic [IDX_W-1:0]  gidx  [GNT_N];
  logic [1:0]        n_in;
  logic [1:0]        n_acc;
  logic [1:0]        n_gnt;
  logic [OCC_W-1:0]  free_cnt;
  logic [OCC_W-1:0]  base;
  logic [OCC_W-1:0]  occ_nxt;
  logic              occ_en;
  logic              q_en;

  // ---------------- incoming slots ----------------
  always_comb begin
    for (int s = 0; s < IN_N; s++) begin
      in_e[s].vld    = in_vld[s];
      in_e[s].dst    = in_dst[s*TAG_W +: TAG_W];
      in_e[s].s0.en  = in_a_en[s];
      in_e[s].s0.tag = in_a_tag[s*TAG_W +: TAG_W];
      in_e[s].s0.rdy = in_a_rdy[s];
      in_e[s].s1.en  = in_b_en[s];
      in_e[s].s1.tag = in_b_tag[s*TAG_W +: TAG_W];
      in_e[s].s1.rdy = in_b_rdy[s];
    end
    // pack: a lone slot-1 instruction moves to the first new position
    nw[0] = in_vld[0] ? in_e[0] : in_e[1];
    nw[1] = in_e[1];
  end

  assign n_in     = {1'b0, in_vld[0]} + {1'b0, in_vld[1]};
  assign free_cnt = OCC_W'(DEPTH) - occ;
  assign in_rdy   = (free_cnt >= OCC_W'(n_in));
  assign n_acc    = in_rdy ? n_in : 2'd0;

  // ---------------- selection ----------------
  collapse_iq_pick #(.DEPTH(DEPTH)) u_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (q),
    .take (take),
    .gvld (gnt_vld),
    .gidx (gidx)
  );

  assign n_gnt = {1'b0, gnt_vld[0]} + {1'b0, gnt_vld[1]};

  always_comb begin
    for (int k = 0; k < GNT_N; k++)
      gnt_dst[k*TAG_W +: TAG_W] = gnt_vld[k] ? q[gidx[k]].dst : '0;
  end

  // ---------------- collapse and append ----------------
  assign base = occ - OCC_W'(n_gnt);

  collapse_iq_shift #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_shift (
    .q    (q),
    .take (take),
    .base (base),
    .nw   (nw),
    .n_new(n_acc),
    .qn   (q_sh)
  );

  // ---------------- wakeup on the next-state image ----------------
  for (genvar i = 0; i < DEPTH; i++) begin : g_wake
    collapse_iq_wake #(.WK_N(WK_N)) u_wake (
      .e_i   (q_sh[i]),
      .wk_vld(wk_vld),
      .wk_tag(wk_tag),
      .e_o   (q_nx[i])
    );
  end

  // ---------------- next state and enables ----------------
  assign occ_nxt = occ + OCC_W'(n_acc) - OCC_W'(n_gnt);
  assign occ_en  = (n_acc != 2'd0) || (n_gnt != 2'd0);
  assign q_en    = occ_en || (|wk_vld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (q_en) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= q_nx[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_nxt;
  end

  // ---------------- checks ----------------
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH))
    else $error("occupancy above depth"); // R2

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ == OCC_W'(DEPTH)) && (|in_vld)) |-> !in_rdy)
    else $error("full queue accepted input"); // R3

  AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_vld == '0) && !(in_rdy && (|in_vld))) |=> $stable(occ))
    else $error("occupancy moved without grant or write"); // R6

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        AST_PACKED: assert (q[i].vld == (i < int'(occ)))
          else $error("entry %0d breaks the packed layout", i); // R2
      end
    end
  end

endmodule

// File: tb/collapse_iq_bench.sv
module collapse_iq_bench;
  import collapse_iq_pkg::*;

  localparam int CLK_P = 10;

  logic                   clk;
  logic                   rst_n;
  logic [1:0]             in_vld;
  logic [2*TAG_W-1:0]     in_dst;
  logic [1:0]             in_a_en;
  logic [2*TAG_W-1:0]     in_a_tag;
  logic [1:0]             in_a_rdy;
  logic [1:0]             in_b_en;
  logic [2*TAG_W-1:0]     in_b_tag;
  logic [1:0]             in_b_rdy;
  logic                   in_rdy;
  logic [1:0]             wk_vld;
  logic [2*TAG_W-1:0]     wk_tag;
  logic [1:0]             gnt_vld;
  logic [2*TAG_W-1:0]     gnt_dst;
  logic [3:0]             occ;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  collapse_iq u_collapse_iq (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_dst(in_dst),
    .in_a_en(in_a_en), .in_a_tag(in_a_tag), .in_a_rdy(in_a_rdy),
    .in_b_en(in_b_en), .in_b_tag(in_b_tag), .in_b_rdy(in_b_rdy),
    .in_rdy(in_rdy), .wk_vld(wk_vld), .wk_tag(wk_tag),
    .gnt_vld(gnt_vld), .gnt_dst(gnt_dst), .occ(occ)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // one cycle of stimulus plus the outputs expected before the next edge
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] iv;
    logic [5:0] d0; logic [5:0] a0; logic r0;
    logic [5:0] d1; logic [5:0] a1; logic r1;
    logic [1:0] wv; logic [5:0] w0; logic [5:0] w1;
    logic       erdy;
    logic [3:0] eocc;
    logic [1:0] egv; logic [5:0] eg0; logic [5:0] eg1;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd0, 2'd0, 6'd0, 6'd0},   // R1 idle after reset
    '{4'd2,  2'd3, 6'd1, 6'd10,1'b0, 6'd2, 6'd11,1'b1, 2'd0, 6'd0, 6'd0, 1'b1, 4'd0, 2'd0, 6'd0, 6'd0},   // R2 R10 write A,B; B not grantable yet
    '{4'd5,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd2, 2'd1, 6'd2, 6'd0},   // R5 only B ready
    '{4'd7,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd1, 6'd10,6'd0, 1'b1, 4'd1, 2'd0, 6'd0, 6'd0},   // R7 wake A, no grant same cycle
    '{4'd7,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd1, 2'd1, 6'd1, 6'd0},   // R7 A granted next cycle
    '{4'd2,  2'd3, 6'd3, 6'd12,1'b0, 6'd4, 6'd13,1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd0, 2'd0, 6'd0, 6'd0},   // R2 write C,D
    '{4'd2,  2'd3, 6'd5, 6'd14,1'b1, 6'd6, 6'd15,1'b1, 2'd0, 6'd0, 6'd0, 1'b1, 4'd2, 2'd0, 6'd0, 6'd0},   // R2 write E,F
    '{4'd5,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd1, 6'd13,6'd0, 1'b1, 4'd4, 2'd3, 6'd5, 6'd6},   // R5 two grants skip C,D
    '{4'd6,  2'd3, 6'd7, 6'd16,1'b1, 6'd8, 6'd17,1'b1, 2'd0, 6'd0, 6'd0, 1'b1, 4'd2, 2'd1, 6'd4, 6'd0},   // R6 survivor D woke
    '{4'd6,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd1, 6'd12,6'd0, 1'b1, 4'd3, 2'd3, 6'd7, 6'd8},   // R6 order C,G,H kept
    '{4'd10, 2'd3, 6'd9, 6'd18,1'b0, 6'd20,6'd19,1'b1, 2'd0, 6'd0, 6'd0, 1'b1, 4'd1, 2'd1, 6'd3, 6'd0},   // R10 write with grant
    '{4'd10, 2'd3, 6'd21,6'd50,1'b0, 6'd22,6'd51,1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd2, 2'd1, 6'd20,6'd0},   // R10 J behind I
    '{4'd2,  2'd3, 6'd23,6'd52,1'b0, 6'd24,6'd53,1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd3, 2'd0, 6'd0, 6'd0},   // R2 fill
    '{4'd2,  2'd3, 6'd25,6'd54,1'b0, 6'd26,6'd55,1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd5, 2'd0, 6'd0, 6'd0},   // R2 fill
    '{4'd3,  2'd3, 6'd27,6'd56,1'b1, 6'd28,6'd57,1'b1, 2'd0, 6'd0, 6'd0, 1'b0, 4'd7, 2'd0, 6'd0, 6'd0},   // R3 one free, two offered
    '{4'd9,  2'd2, 6'd0, 6'd0, 1'b0, 6'd27,6'd56,1'b1, 2'd0, 6'd0, 6'd0, 1'b1, 4'd7, 2'd0, 6'd0, 6'd0},   // R9 lone slot 1
    '{4'd3,  2'd3, 6'd40,6'd0, 1'b1, 6'd41,6'd0, 1'b1, 2'd0, 6'd0, 6'd0, 1'b0, 4'd8, 2'd1, 6'd27,6'd0},   // R3 full refused, R9 Q granted
    '{4'd3,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd7, 2'd0, 6'd0, 6'd0},   // R3 refused pair absent
    '{4'd8,  2'd1, 6'd29,6'd58,1'b0, 6'd0, 6'd0, 1'b0, 2'd3, 6'd58,6'd18, 1'b1, 4'd7, 2'd0, 6'd0, 6'd0},  // R8 wake new S and I
    '{4'd8,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd8, 2'd3, 6'd9, 6'd29},   // R8 I oldest, S youngest
    '{4'd7,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd1, 6'd55,6'd0, 1'b1, 4'd6, 2'd0, 6'd0, 6'd0},   // R7 wake P
    '{4'd6,  2'd0, 6'd0, 6'd0, 1'b0, 6'd0, 6'd0, 1'b0, 2'd0, 6'd0, 6'd0, 1'b1, 4'd6, 2'd1, 6'd26,6'd0}    // R6 P granted
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] iv, input int d0, input int a0, input logic r0,
                     input int d1, input int a1, input logic r1,
                     input logic [1:0] wv, input int w0, input int w1);
    in_vld   = iv;
    in_dst   = {TAG_W'(d1), TAG_W'(d0)};
    in_a_en  = 2'b11;
    in_a_tag = {TAG_W'(a1), TAG_W'(a0)};
    in_a_rdy = {r1, r0};
    in_b_en  = 2'b00;
    in_b_tag = '0;
    in_b_rdy = 2'b00;
    wk_vld   = wv;
    wk_tag   = {TAG_W'(w1), TAG_W'(w0)};
  endtask

  task automatic look(input string req, input int e_occ, input int e_rdy,
                      input int e_gv, input int e_g0, input int e_g1);
    chk(req, "occ", int'(occ), e_occ);
    chk(req, "in_rdy", int'(in_rdy), e_rdy);
    chk(req, "gnt_vld", int'(gnt_vld), e_gv);
    if (e_gv[0]) chk(req, "gnt slot0", int'(gnt_dst[5:0]), e_g0);
    if (e_gv[1]) chk(req, "gnt slot1", int'(gnt_dst[11:6]), e_g1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    put(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    repeat (2) @(negedge clk);
    #1;
    look("R1", 0, 1, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      put(VEC[v].iv, int'(VEC[v].d0), int'(VEC[v].a0), VEC[v].r0,
          int'(VEC[v].d1), int'(VEC[v].a1), VEC[v].r1,
          VEC[v].wv, int'(VEC[v].w0), int'(VEC[v].w1));
      #1;
      look($sformatf("R%0d", VEC[v].req), int'(VEC[v].eocc), int'(VEC[v].erdy),
           int'(VEC[v].egv), int'(VEC[v].eg0), int'(VEC[v].eg1));
    end

    // R1: reset in the middle of traffic empties the queue
    @(negedge clk);
    put(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    #1;
    chk("R6", "occ before reset", int'(occ), 5);
    rst_n = 1'b0;
    #1;
    look("R1", 0, 1, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    look("R1", 0, 1, 0, 0, 0);

    // R4: two-source entry T and source-less entry U
    @(negedge clk);
    put(2'b11, 30, 60, 1, 31, 62, 0, 2'b00, 0, 0);
    in_a_en  = 2'b01;
    in_b_en  = 2'b01;
    in_b_tag = {TAG_W'(0), TAG_W'(61)};
    in_b_rdy = 2'b00;
    #1;
    look("R10", 0, 1, 0, 0, 0);
    @(negedge clk);
    put(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    #1;
    look("R4", 2, 1, 1, 31, 0);
    @(negedge clk);
    put(2'b00, 0, 0, 0, 0, 0, 0, 2'b01, 61, 0);
    #1;
    look("R7", 1, 1, 0, 0, 0);
    @(negedge clk);
    put(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
    #1;
    look("R4", 1, 1, 1, 30, 0);
    @(negedge clk);
    #1;
    look("R6", 0, 1, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule